// File: doc/BRIEF.md
# PWM Event Interrupt Collector

This block collects the event pulses produced by a multi-channel PWM controller and turns them into a single registered interrupt line. Per-channel period-end and fault pulses are captured as sticky flags in a first status group. Per-comparator match and update pulses go into a second status group, together with the status of a synchronous-channel transfer engine. Each group has its own mask. Each mask is changed only through a set port and a clear port, where a 1 bit acts and a 0 bit does nothing.

Software reaches the block over a small register bus with eight word addresses. Reading a group's status address returns its flags one cycle later and clears the sticky flags of that group only. Two transfer-engine bits are not stored. They show the engine's level inputs as they are in the cycle of the read. An event that lands in the same cycle as a clearing read is kept, so no event is lost.

Top module: `pwm_irq_hub`

## Requirements
- R1: After reset, all status flags and both masks are 0, `irq` is 0 and `bus_rdata` is 0. A read of any of the eight addresses returns 0.
- R2: Group 1 status is read at address 3. A pulse on `ev_period[i]` sets bit i. A pulse on `ev_fault[i]` sets bit NCHAN+i (bits 0..3 and 4..7 by default). A flag stays set until its group is read.
- R3: A read (`bus_sel`, `bus_rd`) returns the addressed register on `bus_rdata` in the following cycle. A read of address 3 clears every group 1 flag.
- R4: Group 2 status is read at address 7. The bits are: `ev_cmp_match[i]` at bit i, `ev_cmp_update[i]` at bit NCMP+i, write-ready at 2*NCMP (16), end-of-transfer at 2*NCMP+1 (17), buffer-empty at 2*NCMP+2 (18) and underrun at 2*NCMP+3 (19). A read of address 7 clears the match, update, write-ready and underrun flags.
- R5: Bits 17 and 18 of group 2 show `xfer_end_lvl` and `xfer_bufe_lvl` as they are in the read cycle. A read does not clear them.
- R6: A write to address 0 (group 1) or address 4 (group 2) sets each mask bit whose data bit is 1. Zero bits and data bits above the group width have no effect. The masks read back at addresses 2 and 6.
- R7: A write to address 1 (group 1) or address 5 (group 2) clears each mask bit whose data bit is 1. Zero bits have no effect.
- R8: `irq` is a register. It is 1 exactly one cycle after a cycle in which some status bit and its mask bit are both 1. It returns to 0 one cycle after no such pair remains.
- R9: An event that arrives in the same cycle as a clearing read of its group leaves the flag set. That read returns the flags as they were before the event.
- R10: A read of one group's status leaves the other group's flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| ev_period | input | NCHAN (4) | Per-channel period-end pulses |
| ev_fault | input | NCHAN (4) | Per-channel fault pulses |
| ev_cmp_match | input | NCMP (8) | Per-comparator match pulses |
| ev_cmp_update | input | NCMP (8) | Per-comparator update pulses |
| xfer_wr_ready | input | 1 | Transfer engine write-ready pulse |
| xfer_underrun | input | 1 | Transfer engine underrun pulse |
| xfer_end_lvl | input | 1 | Transfer engine end-of-transfer level |
| xfer_bufe_lvl | input | 1 | Transfer engine buffer-empty level |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the bus makes at most one access per cycle. They also assume that an enable write and a disable write never reach the same group in the same cycle, which the single address makes true. Event inputs may be held for any number of cycles, but the sticky-flag properties compare against the pulse seen in the previous cycle. The stimulus therefore drives each event as a one-cycle pulse on the falling clock edge. The level inputs are held steady across every read that samples them.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;

  // Word addresses of the register bus
  typedef enum logic [2:0] {
    A_G1_SET  = 3'd0,
    A_G1_CLR  = 3'd1,
    A_G1_MASK = 3'd2,
    A_G1_STAT = 3'd3,
    A_G2_SET  = 3'd4,
    A_G2_CLR  = 3'd5,
    A_G2_MASK = 3'd6,
    A_G2_STAT = 3'd7
  } reg_addr_e;

  // Transfer-engine bits appended above the comparator bits of group 2
  localparam int XFER_BITS = 4;

endpackage

// File: rtl/pwm_irq_flagbank.sv
module pwm_irq_flagbank #(
  parameter int              W     = 8,
  parameter logic [W-1:0]    LEVEL = '0   // bits that follow the input live
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic         clr,
  output logic [W-1:0] flags
);

  localparam logic [W-1:0] STICKY = ~LEVEL;

  logic [W-1:0] q;

  // An event in the clearing cycle wins over the clear
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((clr ? '0 : q) | ev) & STICKY;
  end

  assign flags = (q & STICKY) | (ev & LEVEL);

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|(ev & STICKY)) |=> ((flags & $past(ev) & STICKY) == ($past(ev) & STICKY))); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr && ev == '0) |=> ((flags & STICKY) == '0)); // R3
  AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((flags & $past(flags) & STICKY) == ($past(flags) & STICKY))); // R2

endmodule

// File: rtl/pwm_irq_maskreg.sv
module pwm_irq_maskreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] mask
);

  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (set_en) mask <= mask | data;
    else if (clr_en) mask <= mask & ~data;
  end

  AST_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((mask & $past(data)) == $past(data) && (mask & $past(mask)) == $past(mask))); // R6
  AST_CLR_ONLY_REMOVES: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((mask & $past(data)) == '0 && (mask & ~$past(mask)) == '0)); // R7
  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(mask)); // R6

endmodule

// File: rtl/pwm_irq_regif.sv
module pwm_irq_regif
  import pwm_irq_pkg::*;
#(
  parameter int DW = 32,
  parameter int W1 = 8,
  parameter int W2 = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [W1-1:0] st1,
  input  logic [W2-1:0] st2,
  input  logic [W1-1:0] m1,
  input  logic [W2-1:0] m2,
  output logic [W1-1:0] wd1,
  output logic [W2-1:0] wd2,
  output logic          set1,
  output logic          dis1,
  output logic          set2,
  output logic          dis2,
  output logic          clr1,
  output logic          clr2,
  output logic [DW-1:0] bus_rdata
);

  reg_addr_e    addr;
  logic         wr_go, rd_go;
  logic [DW-1:0] rd_mux;
  logic         unused_wbits;

  assign addr  = reg_addr_e'(bus_addr);
  assign wr_go = bus_sel && bus_wr;
  assign rd_go = bus_sel && bus_rd;

  assign wd1 = bus_wdata[W1-1:0];
  assign wd2 = bus_wdata[W2-1:0];
  assign unused_wbits = ^bus_wdata[DW-1:W2];

  assign set1 = wr_go && addr == A_G1_SET;
  assign dis1 = wr_go && addr == A_G1_CLR;
  assign set2 = wr_go && addr == A_G2_SET;
  assign dis2 = wr_go && addr == A_G2_CLR;
  assign clr1 = rd_go && addr == A_G1_STAT;
  assign clr2 = rd_go && addr == A_G2_STAT;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_G1_MASK: rd_mux[W1-1:0] = m1;
      A_G1_STAT: rd_mux[W1-1:0] = st1;
      A_G2_MASK: rd_mux[W2-1:0] = m2;
      A_G2_STAT: rd_mux[W2-1:0] = st2;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_mux;
  end

  AST_MASK1_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_go && addr == A_G1_MASK) |=> (bus_rdata[W1-1:0] == $past(m1))); // R6
  AST_STAT2_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_go && addr == A_G2_STAT) |=> (bus_rdata[W2-1:0] == $past(st2))); // R4

endmodule

// File: rtl/pwm_irq_hub.sv
module pwm_irq_hub
  import pwm_irq_pkg::*;
#(
  parameter int NCHAN = 4,
  parameter int NCMP  = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NCHAN-1:0] ev_period,
  input  logic [NCHAN-1:0] ev_fault,
  input  logic [NCMP-1:0]  ev_cmp_match,
  input  logic [NCMP-1:0]  ev_cmp_update,
  input  logic             xfer_wr_ready,
  input  logic             xfer_underrun,
  input  logic             xfer_end_lvl,
  input  logic             xfer_bufe_lvl,
  output logic             irq
);

  localparam int W1       = 2 * NCHAN;
  localparam int W2       = 2 * NCMP + XFER_BITS;
  localparam int B_END    = 2 * NCMP + 1;
  localparam logic [W2-1:0] G2_LIVE = W2'(3) << B_END;

  logic [W1-1:0] ev1, st1, m1, wd1;
  logic [W2-1:0] ev2, st2, m2, wd2;
  logic          set1, dis1, set2, dis2, clr1, clr2;
  logic          pend;

  assign ev1 = {ev_fault, ev_period};
  assign ev2 = {xfer_underrun, xfer_bufe_lvl, xfer_end_lvl, xfer_wr_ready,
                ev_cmp_update, ev_cmp_match};

  pwm_irq_regif #(.DW(DW), .W1(W1), .W2(W2)) u_regif (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .st1(st1), .st2(st2), .m1(m1), .m2(m2),
    .wd1(wd1), .wd2(wd2),
    .set1(set1), .dis1(dis1), .set2(set2), .dis2(dis2),
    .clr1(clr1), .clr2(clr2),
    .bus_rdata(bus_rdata)
  );

  pwm_irq_flagbank #(.W(W1), .LEVEL('0)) u_flags1 (
    .clk(clk), .rst(rst), .ev(ev1), .clr(clr1), .flags(st1)
  );

  pwm_irq_flagbank #(.W(W2), .LEVEL(G2_LIVE)) u_flags2 (
    .clk(clk), .rst(rst), .ev(ev2), .clr(clr2), .flags(st2)
  );

  pwm_irq_maskreg #(.W(W1)) u_mask1 (
    .clk(clk), .rst(rst), .set_en(set1), .clr_en(dis1), .data(wd1), .mask(m1)
  );

  pwm_irq_maskreg #(.W(W2)) u_mask2 (
    .clk(clk), .rst(rst), .set_en(set2), .clr_en(dis2), .data(wd2), .mask(m2)
  );

  assign pend = (|(st1 & m1)) || (|(st2 & m2));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pend;
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pend) |=> !irq); // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(pend)); // R8
  AST_LIVE_END: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_rd && bus_addr == 3'd7) |=> (bus_rdata[B_END] == $past(xfer_end_lvl))); // R5
  AST_G1_READ_SPARES_G2: assert property (@(posedge clk) disable iff (rst)
    (clr1 && !clr2) |=> ((st2 & $past(st2) & ~G2_LIVE) == ($past(st2) & ~G2_LIVE))); // R10

endmodule

// File: tb/pwm_irq_hub_tb.sv
module pwm_irq_hub_tb;

  localparam int NCHAN = 4;
  localparam int NCMP  = 8;
  localparam int DW    = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]       bus_addr = '0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic [NCHAN-1:0] ev_period = '0, ev_fault = '0;
  logic [NCMP-1:0]  ev_cmp_match = '0, ev_cmp_update = '0;
  logic             xfer_wr_ready = 1'b0, xfer_underrun = 1'b0;
  logic             xfer_end_lvl = 1'b0, xfer_bufe_lvl = 1'b0;
  logic             irq;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pwm_irq_hub #(.NCHAN(NCHAN), .NCMP(NCMP), .DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_period(ev_period), .ev_fault(ev_fault),
    .ev_cmp_match(ev_cmp_match), .ev_cmp_update(ev_cmp_update),
    .xfer_wr_ready(xfer_wr_ready), .xfer_underrun(xfer_underrun),
    .xfer_end_lvl(xfer_end_lvl), .xfer_bufe_lvl(xfer_bufe_lvl),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // g1: {fault, period}; g2: {underrun, wr_ready, update, match}
  task automatic pulse(input logic [7:0] g1, input logic [17:0] g2);
    @(negedge clk);
    {ev_fault, ev_period} = g1;
    {xfer_underrun, xfer_wr_ready, ev_cmp_update, ev_cmp_match} = g2;
    @(negedge clk);
    {ev_fault, ev_period} = '0;
    {xfer_underrun, xfer_wr_ready, ev_cmp_update, ev_cmp_match} = '0;
  endtask

  // Status bit position in group 2 for sticky source index b
  function automatic int g2_pos(input int b);
    return (b < 17) ? b : 19;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog (R1..R10 incomplete) got=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m1, m2;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rdata after reset", bus_rdata, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 register reads zero", d, 32'd0);
    end

    // R2 / R3: every group 1 source, read then read-back empty
    for (int b = 0; b < 8; b++) begin
      pulse(8'(1 << b), '0);
      rd(3'd3, d);
      chk("R2 group1 flag position", d, 32'(1 << b));
      rd(3'd3, d);
      chk("R3 group1 cleared by read", d, 32'd0);
    end
    // several at once, flag persists over idle cycles
    pulse(8'hA5, '0);
    repeat (5) @(negedge clk);
    rd(3'd3, d);
    chk("R2 group1 multi flags held", d, 32'hA5);

    // R4: every sticky group 2 source
    for (int b = 0; b < 18; b++) begin
      pulse('0, 18'(1 << b));
      rd(3'd7, d);
      chk("R4 group2 flag position", d, 32'(1 << g2_pos(b)));
      rd(3'd7, d);
      chk("R4 group2 cleared by read", d, 32'd0);
    end

    // R10: group isolation
    pulse(8'h05, 18'h00001);
    rd(3'd3, d);
    chk("R10 group1 read", d, 32'h5);
    rd(3'd7, d);
    chk("R10 group2 kept after group1 read", d, 32'h1);
    pulse(8'h05, 18'h00001);
    rd(3'd7, d);
    chk("R10 group2 read", d, 32'h1);
    rd(3'd3, d);
    chk("R10 group1 kept after group2 read", d, 32'h5);

    // R5: live transfer levels at bits 17 and 18
    @(negedge clk);
    xfer_end_lvl = 1'b1; xfer_bufe_lvl = 1'b1;
    rd(3'd7, d);
    chk("R5 live levels visible", d, 32'h60000);
    rd(3'd7, d);
    chk("R5 live levels not cleared", d, 32'h60000);
    xfer_bufe_lvl = 1'b0;
    rd(3'd7, d);
    chk("R5 end level alone", d, 32'h20000);
    xfer_end_lvl = 1'b0;
    rd(3'd7, d);
    chk("R5 levels dropped", d, 32'd0);

    // R6 / R7: mask set and clear sweeps
    m1 = '0;
    for (int b = 0; b < 8; b++) begin
      wr(3'd0, 32'(1 << b));
      m1 = m1 | 32'(1 << b);
      rd(3'd2, d);
      chk("R6 group1 mask set accumulates", d, m1);
    end
    wr(3'd0, 32'd0);
    rd(3'd2, d);
    chk("R6 zero write no effect", d, m1);
    wr(3'd1, 32'h0F);
    m1 = m1 & ~32'h0F;
    rd(3'd2, d);
    chk("R7 group1 mask clear", d, m1);
    wr(3'd1, 32'd0);
    rd(3'd2, d);
    chk("R7 zero clear no effect", d, m1);
    wr(3'd1, 32'hFF);
    rd(3'd2, d);
    chk("R7 group1 mask cleared", d, 32'd0);

    m2 = 32'hAAAAA;
    wr(3'd4, m2);
    rd(3'd6, d);
    chk("R6 group2 mask set", d, m2);
    wr(3'd5, 32'h0000F);
    m2 = m2 & ~32'h0000F;
    rd(3'd6, d);
    chk("R7 group2 mask clear", d, m2);
    wr(3'd4, 32'hFFFFFFFF);
    rd(3'd6, d);
    chk("R6 upper data bits ignored", d, 32'hFFFFF);
    wr(3'd5, 32'hFFFFFFFF);
    rd(3'd6, d);
    chk("R7 group2 mask cleared", d, 32'd0);

    // R8: interrupt timing
    pulse(8'h04, '0);
    @(negedge clk);
    chk("R8 masked flag no irq", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'h04);
    chk("R8 irq one cycle after mask", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    rd(3'd3, d);
    chk("R8 irq held in read cycle", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R8 irq dropped after read", {31'd0, irq}, 32'd0);
    pulse(8'h04, '0);
    chk("R8 irq not yet after event", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq after event", {31'd0, irq}, 32'd1);
    rd(3'd3, d);
    wr(3'd1, 32'h04);
    wr(3'd4, 32'h40000);
    @(negedge clk);
    xfer_bufe_lvl = 1'b1;
    @(negedge clk);
    chk("R8 irq from live level", {31'd0, irq}, 32'd1);
    xfer_bufe_lvl = 1'b0;
    @(negedge clk);
    chk("R8 irq follows level low", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'h40000);

    // R9: event coincident with clearing read
    pulse(8'h01, '0);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'd3; ev_period = 4'b0011;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0; ev_period = '0;
    chk("R9 read shows pre-event flags", bus_rdata, 32'h1);
    rd(3'd3, d);
    chk("R9 coincident events kept", d, 32'h3);
    pulse('0, 18'h10000);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'd7;
    xfer_wr_ready = 1'b1; ev_cmp_update = 8'h01;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0; xfer_wr_ready = 1'b0; ev_cmp_update = '0;
    chk("R9 group2 read pre-event", bus_rdata, 32'h10000);
    rd(3'd7, d);
    chk("R9 group2 coincident kept", d, 32'h10100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule